// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single clause 22 management transactions on an MDC/MDIO pair. Each transaction reads or writes one 16-bit PHY register. A client pulses a request together with a read/write flag, a 5-bit PHY address, a 5-bit register number and, for writes, 16 bits of data. The block then generates the MDC clock and drives MDIO for the whole frame. It samples the returned bits on a read, and it signals completion with a one-cycle done pulse.

MDC is derived from the system clock. Each MDC half period lasts `HALF_DIV` system clocks, and `HALF_DIV` must be at least 2. Only one transaction is in progress at a time. While a frame is running the block reports busy and discards new requests. Between frames the MDIO driver is released and MDC rests low.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 bit periods in which the MDIO output is enabled and driven high (bit indices 0 to 31, counted from 0 at the first MDC rising edge).
- R2: Bit 32 drives 0 and bit 33 drives 1. The two operation bits 34 and 35 carry 1 then 0 for a read, and 0 then 1 for a write.
- R3: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register number. Both fields are sent most significant bit first and driven with output enable high.
- R4: A write releases the output (enable 0, data 0) for bits 46 and 47. It drives the 16 data bits MSB first on bits 48 to 63 and releases the output again for bit 64, so the frame has exactly 65 MDC rising edges.
- R5: A read keeps the output released (enable 0, data 0) from bit 46 to bit 63, for exactly 64 MDC rising edges. It captures MDIO input on bits 47 to 62, shifting left and inserting each bit at bit 0, so bit 47 ends up as rd_data[15].
- R6: The low and high halves of every MDC period each last HALF_DIV system clocks. The MDIO output and enable change only while MDC is low. The input is sampled on the system clock edge that ends the high half.
- R7: At the end of a frame MDC, mdio_o and mdio_oe are all 0. Done is a one-cycle pulse, visible after edge A + L*2*HALF_DIV, where A is the accepting edge and L is the frame's bit count.
- R8: Busy is 1 from the edge that accepts a request until the edge that raises done. A request arriving while busy is discarded: it does not change the running frame and produces no done.
- R9: rd_data changes only when a read completes. It then holds its value, and write frames leave it unchanged.
- R10: After reset, mdc, mdio_o, mdio_oe, busy, done and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transaction (taken when not busy) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The hardest situation to reach from the ports is a request that arrives in the middle of a running frame. It must leave no trace on the wire, in rd_data or in the done count. The bench pulses a request with entirely different fields several bit periods into a frame. The scoreboard then confirms that the captured bit stream still matches the original request and that only one completion arrives. Read data ordering is pinned down by a PHY model that changes its answer on every MDC falling edge, with patterns carrying a lone LSB or a lone MSB. It holds the line high outside the data window, so a shifted sampling window shows up as wrong data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] START_BITS = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
endpackage

// File: rtl/mdio_halfcnt.sv
module mdio_halfcnt #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PA_W    = 5,
  parameter int RA_W    = 5,
  parameter int D_W     = 16,
  parameter int HDR_W   = PRE_LEN + 4 + PA_W + RA_W,
  parameter int FW      = HDR_W + 3 + D_W,
  parameter int BW      = $clog2(FW + 1)
) (
  input  logic            wr,
  input  logic [PA_W-1:0] pa,
  input  logic [RA_W-1:0] ra,
  input  logic [D_W-1:0]  wd,
  output logic [FW-1:0]   tx,
  output logic [FW-1:0]   oe,
  output logic [BW-1:0]   len
);
  logic [HDR_W-1:0] hdr;

  always_comb begin
    hdr = {{PRE_LEN{1'b1}}, START_BITS, (wr ? OP_WRITE : OP_READ), pa, ra};
    if (wr) begin
      tx  = {hdr, 2'b00, wd, 1'b0};
      oe  = {{HDR_W{1'b1}}, 2'b00, {D_W{1'b1}}, 1'b0};
      len = BW'(FW);
    end else begin
      tx  = {hdr, {(FW - HDR_W){1'b0}}};
      oe  = {{HDR_W{1'b1}}, {(FW - HDR_W){1'b0}}};
      len = BW'(FW - 1);
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int PRE_LEN  = 32,
  parameter int PA_W     = 5,
  parameter int RA_W     = 5,
  parameter int D_W      = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            req_wr,
  input  logic [PA_W-1:0] req_phy,
  input  logic [RA_W-1:0] req_reg,
  input  logic [D_W-1:0]  req_wdata,
  output logic            busy,
  output logic            done,
  output logic [D_W-1:0]  rd_data,
  output logic            mdc,
  output logic            mdio_o,
  output logic            mdio_oe,
  input  logic            mdio_i
);
  localparam int HDR_W = PRE_LEN + 4 + PA_W + RA_W;
  localparam int FW    = HDR_W + 3 + D_W;
  localparam int BW    = $clog2(FW + 1);
  localparam int WIN_LO = HDR_W + 1;
  localparam int WIN_HI = HDR_W + D_W;

  phase_e         phase;
  logic           busy_q, done_q, mdc_q, mdo_q, oe_q, is_wr;
  logic [FW-1:0]  tx_sh, oe_sh, f_tx, f_oe;
  logic [BW-1:0]  bit_idx, last_idx, f_len;
  logic [D_W-1:0] rd_shift, rd_q;
  logic           tick, accept, in_win;

  assign accept = (phase == PH_IDLE) && req;
  assign in_win = (bit_idx >= BW'(WIN_LO)) && (bit_idx <= BW'(WIN_HI));

  mdio_halfcnt #(.HALF_DIV(HALF_DIV)) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .run    (phase != PH_IDLE),
    .expire (tick)
  );

  mdio_frame_build #(
    .PRE_LEN(PRE_LEN), .PA_W(PA_W), .RA_W(RA_W), .D_W(D_W),
    .HDR_W(HDR_W), .FW(FW), .BW(BW)
  ) u_build (
    .wr  (req_wr),
    .pa  (req_phy),
    .ra  (req_reg),
    .wd  (req_wdata),
    .tx  (f_tx),
    .oe  (f_oe),
    .len (f_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      mdc_q    <= 1'b0;
      mdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      is_wr    <= 1'b0;
      tx_sh    <= '0;
      oe_sh    <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      rd_shift <= '0;
      rd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req) begin
            phase    <= PH_LOW;
            busy_q   <= 1'b1;
            is_wr    <= req_wr;
            tx_sh    <= f_tx;
            oe_sh    <= f_oe;
            bit_idx  <= '0;
            last_idx <= f_len - 1'b1;
            mdo_q    <= f_tx[FW-1];
            oe_q     <= f_oe[FW-1];
            mdc_q    <= 1'b0;
          end
        end
        PH_LOW: begin
          if (tick) begin
            phase <= PH_HIGH;
            mdc_q <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            mdc_q <= 1'b0;
            if (!is_wr && in_win) begin
              rd_shift <= {rd_shift[D_W-2:0], mdio_i};
            end
            if (bit_idx == last_idx) begin
              phase  <= PH_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              mdo_q  <= 1'b0;
              oe_q   <= 1'b0;
              if (!is_wr) begin
                rd_q <= rd_shift;
              end
            end else begin
              phase   <= PH_LOW;
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= tx_sh << 1;
              oe_sh   <= oe_sh << 1;
              mdo_q   <= tx_sh[FW-2];
              oe_q    <= oe_sh[FW-2];
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign mdc     = mdc_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int D_W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic [D_W-1:0] rd_data,
  input logic           mdc,
  input logic           mdio_o,
  input logic           mdio_oe
);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_o && !mdio_oe));

  a_r6_out_moves_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

  a_r6_high_min: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |=> mdc);

  a_r6_low_min: assert property (@(posedge clk) disable iff (rst)
    ($fell(mdc) && busy) |=> !mdc);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_start_driven: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!mdc && mdio_oe && mdio_o));

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> done);
endmodule

bind mdio_master mdio_master_chk #(.D_W(D_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .rd_data (rd_data),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  mdio_master #(.HALF_DIV(H)) dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit        wr;
    bit [4:0]  pa;
    bit [4:0]  ra;
    bit [15:0] wd;
    bit [15:0] exp_rd;
    int        acc;
  } item_t;

  item_t     sbq[$];
  int        n_chk = 0;
  int        n_fail = 0;
  int        cyc = 0;
  bit        ended = 0;
  bit [15:0] phy_resp = '0;
  bit [15:0] last_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // expected line state {oe, data} for bit idx, built from R1..R5
  function automatic bit [1:0] exp_bit(input item_t it, input int idx);
    if (idx < 32) return 2'b11;
    if (idx == 32) return 2'b10;
    if (idx == 33) return 2'b11;
    if (idx == 34) return {1'b1, ~it.wr};
    if (idx == 35) return {1'b1, it.wr};
    if (idx <= 40) return {1'b1, it.pa[4 - (idx - 36)]};
    if (idx <= 45) return {1'b1, it.ra[4 - (idx - 41)]};
    if (it.wr && idx >= 48 && idx <= 63) return {1'b1, it.wd[15 - (idx - 48)]};
    return 2'b00;
  endfunction

  // monitor: capture wire, model the PHY, score completions
  bit  cap_d [0:64];
  bit  cap_oe[0:64];
  int  rise_cnt = 0;
  int  run_len = 0;
  bit  prev_mdc = 0, prev_busy = 0, inframe = 0, half_bad = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (busy && !prev_busy) begin
          inframe = 1; run_len = 0; half_bad = 0;
        end
        if (inframe && (mdc != prev_mdc)) begin
          if (run_len != H) half_bad = 1;
          run_len = 0;
        end
        if (inframe) run_len++;
        if (mdc && !prev_mdc && rise_cnt < 65) begin
          cap_d[rise_cnt]  = mdio_o;
          cap_oe[rise_cnt] = mdio_oe;
          rise_cnt++;
        end
        if (!mdc && prev_mdc) begin
          if (rise_cnt >= 47 && rise_cnt <= 62) mdio_i = phy_resp[15 - (rise_cnt - 47)];
          else mdio_i = 1'b1;
        end
        if (done) begin
          if (sbq.size() == 0) begin
            chk(0, "R8 unexpected done", 1, 0);
          end else begin
            item_t it;
            int    len;
            bit    ok1, ok2, ok3, ok4;
            it = sbq.pop_front();
            len = it.wr ? 65 : 64;
            ok1 = 1; ok2 = 1; ok3 = 1; ok4 = 1;
            for (int i = 0; i < len && i < rise_cnt; i++) begin
              bit [1:0] e;
              e = exp_bit(it, i);
              if ({cap_oe[i], cap_d[i]} != e) begin
                if (i < 32) ok1 = 0;
                else if (i < 36) ok2 = 0;
                else if (i < 46) ok3 = 0;
                else ok4 = 0;
              end
            end
            chk(ok1, "R1 preamble", ok1, 1);
            chk(ok2, "R2 start/op", ok2, 1);
            chk(ok3, "R3 addr/reg", ok3, 1);
            if (it.wr) begin
              chk(ok4, "R4 write tail", ok4, 1);
              chk(rise_cnt == 65, "R4 edge count", rise_cnt, 65);
              chk(rd_data == it.exp_rd, "R9 rd_data after write", rd_data, it.exp_rd);
            end else begin
              chk(ok4, "R5 read tail released", ok4, 1);
              chk(rise_cnt == 64, "R5 edge count", rise_cnt, 64);
              chk(rd_data == it.exp_rd, "R5 read data", rd_data, it.exp_rd);
            end
            chk(!half_bad, "R6 half period", half_bad, 0);
            chk(cyc == it.acc + len * 2 * H, "R7 done timing", cyc, it.acc + len * 2 * H);
            chk(!mdc && !mdio_o && !mdio_oe, "R7 idle lines",
                {mdc, mdio_o, mdio_oe}, 0);
          end
          rise_cnt = 0;
          inframe = 0;
        end
      end
      prev_mdc = mdc;
      prev_busy = busy;
    end
  end

  task automatic issue(input bit wr, input bit [4:0] pa, input bit [4:0] ra,
                       input bit [15:0] wd, input bit [15:0] resp, input bit poke);
    item_t it;
    it.wr = wr; it.pa = pa; it.ra = ra; it.wd = wd;
    if (!wr) last_rd = resp;
    it.exp_rd = last_rd;
    phy_resp = resp;
    @(negedge clk);
    req = 1; req_wr = wr; req_phy = pa; req_reg = ra; req_wdata = wd;
    @(negedge clk);
    req = 0;
    it.acc = cyc;
    sbq.push_back(it);
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (poke) begin
      repeat (5 * 2 * H) @(negedge clk);
      req = 1; req_wr = ~wr; req_phy = ~pa; req_reg = ~ra; req_wdata = ~wd;
      @(negedge clk);
      req = 0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R8 single completion", sbq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!mdc && !mdio_o && !mdio_oe, "R10 lines idle", {mdc, mdio_o, mdio_oe}, 0);
    chk(!busy && !done, "R10 busy/done", {busy, done}, 0);
    chk(rd_data == 16'h0, "R10 rd_data", rd_data, 0);
    issue(0, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 0);
    issue(0, 5'h1F, 5'h00, 16'h0000, 16'h0001, 0);
    issue(0, 5'h10, 5'h11, 16'h0000, 16'h8000, 0);
    issue(1, 5'h0A, 5'h15, 16'h1234, 16'hFFFF, 0);
    issue(1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 0);
    issue(0, 5'h03, 5'h0C, 16'h0000, 16'h3C5A, 1);
    issue(1, 5'h15, 5'h0A, 16'h8001, 16'h0F0F, 1);
    issue(0, 5'h00, 5'h00, 16'h0000, 16'hFFFF, 0);
    issue(1, 5'h00, 5'h00, 16'h0000, 16'h1111, 0);
    // R9 hold after completion
    repeat (20) @(negedge clk);
    chk(rd_data == 16'hFFFF, "R9 rd_data held", rd_data, 16'hFFFF);
    finish_run();
  end
endmodule